// File: doc/BRIEF.md
# Dual-Side Doorbell Register Pair

This block holds two 32-bit doorbell registers that let a host-bus agent and a local-bus agent signal each other. The host rings the local side through the host-to-local doorbell. The local side rings the host through the local-to-host doorbell. In each register, only the ringing side can set bits, by writing ones. Only the receiving side can acknowledge bits, by writing ones, which clears them. Each register drives a registered level interrupt toward its receiving side, and each interrupt is gated by its own enable input.

Each side has its own single-cycle register port, with a request, a write flag, a register select, write data and read data. The block also keeps same-cycle accesses from the two buses from colliding. When the host is served, local ready is deasserted for that cycle and for a guard window of `GUARD` cycles after it, so local accesses stall. When the local side is served, host requests in the following guard window are answered with a retry and are not performed. If both sides request while no guard window is open, the host is served and the local side stalls.

Top module: `dbell_pair`

## Requirements
- R1: A host write with `h_sel`=0 sets every host-to-local doorbell bit whose write-data bit is 1. Bits written as 0 keep their value.
- R2: A performed local write with `l_sel`=0 clears every host-to-local doorbell bit whose write-data bit is 1. Bits written as 0 keep their value.
- R3: A performed local write with `l_sel`=1 sets every local-to-host doorbell bit whose write-data bit is 1. Bits written as 0 keep their value.
- R4: A performed host write with `h_sel`=1 clears every local-to-host doorbell bit whose write-data bit is 1. Bits written as 0 keep their value. A host write never sets a local-to-host bit.
- R5: `h_rdata` and `l_rdata` show the register picked by the port's select bit (0 = host-to-local, 1 = local-to-host). Reads and non-write requests leave both registers unchanged.
- R6: `l_irq` is 1 exactly when, one cycle earlier, some host-to-local bit was set and `l_irq_en` was 1.
- R7: `h_irq` is 1 exactly when, one cycle earlier, some local-to-host bit was set and `h_irq_en` was 1.
- R8: Local ready is 0 in a cycle where a host request is performed. It stays 0 for the `GUARD` (default 2) cycles that follow. It then returns to 1 if the host is idle.
- R9: For `GUARD` cycles after a performed local access, every host request gets `h_retry`=1 and `h_done`=0, and has no effect on either register.
- R10: When both sides request in the same cycle with no guard window open, the host access is performed. The local access waits, with ready low, until ready returns, and is then performed.
- R11: After reset, both registers and both interrupts are 0, `l_ready` is 1 and `h_retry` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset |
| h_req | input | 1 | Host access request, one cycle per access |
| h_we | input | 1 | Host write (1) or read (0) |
| h_sel | input | 1 | Host register select: 0 host-to-local, 1 local-to-host |
| h_wdata | input | 32 | Host write data (set mask or clear mask) |
| h_rdata | output | 32 | Contents of the register chosen by h_sel |
| h_done | output | 1 | Host request performed this cycle |
| h_retry | output | 1 | Host request refused, retry later |
| h_irq_en | input | 1 | Enable for the host doorbell interrupt |
| h_irq | output | 1 | Level interrupt toward the host |
| l_req | input | 1 | Local access request, held until ready |
| l_we | input | 1 | Local write (1) or read (0) |
| l_sel | input | 1 | Local register select: 0 host-to-local, 1 local-to-host |
| l_wdata | input | 32 | Local write data (clear mask or set mask) |
| l_rdata | output | 32 | Contents of the register chosen by l_sel |
| l_ready | output | 1 | Local access is accepted this cycle |
| l_irq_en | input | 1 | Enable for the local doorbell interrupt |
| l_irq | output | 1 | Level interrupt toward the local side |

## Verification
The set and clear paths are driven with sparse masks first. They are then driven with masks that overlap bits already set and with all-zero masks, which separates a true write-one-to-set or write-one-to-clear from a plain overwrite or a toggle. Host writes of all ones to the local-to-host register show whether the host can only clear and never set. Interrupt checks are timed one cycle apart, both with the enable high and with it low, which exposes an unregistered or ungated interrupt. The collision tests drive a host access, a local access followed at once by a host access, and simultaneous requests. They measure the stall length and the retry response and confirm that a refused write leaves the register untouched.

// File: rtl/dbell_pkg.sv
// Shared types for the doorbell pair: register-port owner state and the
// select encoding used by both bus ports.
package dbell_pkg;
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_HOST  = 2'd1,
        OWN_LOCAL = 2'd2
    } owner_e;

    localparam logic SEL_H2L = 1'b0;
    localparam logic SEL_L2H = 1'b1;
    localparam int   NREG    = 2;
endpackage

// File: rtl/dbell_arbiter.sv
// Collision guard between the host and local register ports.
// Purpose: serve at most one side per cycle. Host wins ties. A served side
// owns the registers for GUARD further cycles; during that window the local
// side sees ready low (host owner) or the host sees retry (local owner).
// Assumes: GUARD >= 1; host requests last one cycle; local requests are
// held until ready.
module dbell_arbiter
    import dbell_pkg::*;
#(
    parameter int GUARD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic h_req,
    input  logic l_req,
    output logic h_grant,
    output logic h_retry,
    output logic l_grant,
    output logic l_ready
);
    localparam int CW = (GUARD > 1) ? $clog2(GUARD) : 1;

    owner_e        own_q;
    logic [CW-1:0] cnt_q;

    // Grant and refusal decisions for the current cycle.
    always_comb begin
        h_grant = h_req && (own_q != OWN_LOCAL);
        h_retry = h_req && (own_q == OWN_LOCAL);
        l_ready = (own_q != OWN_HOST) && !h_grant;
        l_grant = l_req && l_ready;
    end

    // Track which side owns the registers and how long the guard lasts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q <= OWN_NONE;
            cnt_q <= '0;
        end else if (h_grant) begin
            own_q <= OWN_HOST;
            cnt_q <= CW'(GUARD - 1);
        end else if (l_grant) begin
            own_q <= OWN_LOCAL;
            cnt_q <= CW'(GUARD - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end else begin
            own_q <= OWN_NONE;
        end
    end

    // R8
    host_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(h_grant)) |-> !l_ready);

    // R9
    local_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(l_grant) && h_req) |-> (h_retry && !h_grant));
endmodule

// File: rtl/dbell_reg.sv
// One doorbell register with separate set and clear masks plus a registered,
// enable-gated level interrupt.
// Assumes: set and clear are per-bit masks valid for one cycle. A set wins
// over a clear on the same bit, so no event is lost.
module dbell_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_v,
    input  logic [W-1:0] clr_v,
    input  logic         en,
    output logic [W-1:0] q,
    output logic         irq
);
    logic [W-1:0] q_q;
    logic         irq_q;

    // Apply clear mask, then set mask.
    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= (q_q & ~clr_v) | set_v;
    end

    // Registered level interrupt from the current contents.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= (|q_q) && en;
    end

    assign q   = q_q;
    assign irq = irq_q;

    // R1 R3
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((q_q & $past(set_v)) == $past(set_v)));

    // R2 R4
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((q_q & $past(clr_v) & ~$past(set_v)) == '0));

    // R5
    idle_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (((q_q ^ $past(q_q)) & ~($past(set_v) | $past(clr_v))) == '0));

    // R6 R7
    irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_q == ($past(|q_q) && $past(en))));
endmodule

// File: rtl/dbell_pair.sv
// Top of the doorbell pair: routes each port's writes to the set or clear
// mask of the right register and muxes read-back.
// Register 0 (host-to-local): host sets, local clears, interrupts local.
// Register 1 (local-to-host): local sets, host clears, interrupts host.
// Assumes: single clock, synchronous active-low reset.
module dbell_pair
    import dbell_pkg::*;
#(
    parameter int DW    = 32,
    parameter int GUARD = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_req,
    input  logic          h_we,
    input  logic          h_sel,
    input  logic [DW-1:0] h_wdata,
    output logic [DW-1:0] h_rdata,
    output logic          h_done,
    output logic          h_retry,
    input  logic          h_irq_en,
    output logic          h_irq,
    input  logic          l_req,
    input  logic          l_we,
    input  logic          l_sel,
    input  logic [DW-1:0] l_wdata,
    output logic [DW-1:0] l_rdata,
    output logic          l_ready,
    input  logic          l_irq_en,
    output logic          l_irq
);
    logic          h_grant, l_grant, h_wr, l_wr;
    logic [DW-1:0] set_m [NREG];
    logic [DW-1:0] clr_m [NREG];
    logic [DW-1:0] q_m   [NREG];
    logic          en_m  [NREG];
    logic          irq_m [NREG];

    dbell_arbiter #(.GUARD(GUARD)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .h_req(h_req), .l_req(l_req),
        .h_grant(h_grant), .h_retry(h_retry),
        .l_grant(l_grant), .l_ready(l_ready)
    );

    // Steer performed writes into set and clear masks.
    always_comb begin
        h_wr = h_grant && h_we;
        l_wr = l_grant && l_we;
        set_m[0] = (h_wr && h_sel == SEL_H2L) ? h_wdata : '0;
        clr_m[0] = (l_wr && l_sel == SEL_H2L) ? l_wdata : '0;
        set_m[1] = (l_wr && l_sel == SEL_L2H) ? l_wdata : '0;
        clr_m[1] = (h_wr && h_sel == SEL_L2H) ? h_wdata : '0;
        en_m[0]  = l_irq_en;
        en_m[1]  = h_irq_en;
    end

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        dbell_reg #(.W(DW)) u_reg (
            .clk(clk), .rst_n(rst_n),
            .set_v(set_m[i]), .clr_v(clr_m[i]), .en(en_m[i]),
            .q(q_m[i]), .irq(irq_m[i])
        );
    end

    // Read-back and interrupt routing.
    always_comb begin
        h_rdata = q_m[h_sel];
        l_rdata = q_m[l_sel];
        h_done  = h_grant;
        l_irq   = irq_m[0];
        h_irq   = irq_m[1];
    end

    // R5
    read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!(h_req && h_we)) && $past(!(l_req && l_we)))
        |-> ($stable(q_m[0]) && $stable(q_m[1])));

    // R9
    retry_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(h_retry) && $past(!l_req))
        |-> ($stable(q_m[0]) && $stable(q_m[1])));
endmodule

// File: tb/dbell_pair_bench.sv
module dbell_pair_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_req = 0, h_we = 0, h_sel = 0, h_irq_en = 0;
    logic [31:0] h_wdata = '0;
    logic        l_req = 0, l_we = 0, l_sel = 0, l_irq_en = 0;
    logic [31:0] l_wdata = '0;
    logic [31:0] h_rdata, l_rdata;
    logic        h_done, h_retry, h_irq, l_ready, l_irq;

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dbell_pair u_dbell_pair (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Read a register through the local port (no request, no side effect).
    task automatic peek(logic sel, output logic [31:0] v);
        @(negedge clk);
        l_sel = sel;
        #1 v = l_rdata;
    endtask

    // One-cycle host access; returns at the negedge after the access edge.
    task automatic host_acc(logic we, logic sel, logic [31:0] d,
                            output logic done, output logic retry, output logic rdy);
        @(negedge clk);
        h_req = 1; h_we = we; h_sel = sel; h_wdata = d;
        #1 done = h_done; retry = h_retry; rdy = l_ready;
        @(negedge clk);
        h_req = 0; h_we = 0;
    endtask

    // Local access held until ready; returns at the negedge after acceptance.
    task automatic local_acc(logic we, logic sel, logic [31:0] d, output int stalls);
        @(negedge clk);
        l_req = 1; l_we = we; l_sel = sel; l_wdata = d;
        stalls = 0;
        #1;
        while (!l_ready && stalls < 50) begin
            stalls++;
            @(negedge clk); #1;
        end
        @(negedge clk);
        l_req = 0; l_we = 0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        peek(0, v); chk("R11 h2l reset", v, 0);
        peek(1, v); chk("R11 l2h reset", v, 0);
        chk("R11 irqs", {h_irq, l_irq}, 0);
        chk("R11 ready/retry", {l_ready, h_retry}, 2'b10);
    endtask

    task automatic t_h2l;
        logic d, r, y; int s; logic [31:0] v;
        l_irq_en = 1;
        host_acc(1, 0, 32'h0000_00A5, d, r, y);
        chk("R1 done", d, 1);
        chk("R6 irq not yet", l_irq, 0);
        @(negedge clk); chk("R6 irq one cycle later", l_irq, 1);
        idle(3);
        host_acc(1, 0, 32'h0000_0100, d, r, y);
        idle(3);
        peek(0, v); chk("R1 zeros keep bits", v, 32'h0000_01A5);
        local_acc(1, 0, 32'h0000_0005, s);
        idle(3);
        peek(0, v); chk("R2 clear ones", v, 32'h0000_01A0);
        local_acc(1, 0, 32'h0, s);
        idle(3);
        peek(0, v); chk("R2 zeros no effect", v, 32'h0000_01A0);
        local_acc(1, 0, 32'h0000_01A0, s);
        @(negedge clk); chk("R6 irq drops after clear", l_irq, 0);
        host_acc(1, 0, 32'h8000_0000, d, r, y);
        l_irq_en = 0;
        idle(3); chk("R6 enable gates irq", l_irq, 0);
        local_acc(1, 0, 32'hFFFF_FFFF, s);
        idle(3);
    endtask

    task automatic t_l2h;
        logic d, r, y; int s; logic [31:0] v;
        h_irq_en = 1;
        local_acc(1, 1, 32'h0000_3C00, s);
        chk("R7 irq not yet", h_irq, 0);
        @(negedge clk); chk("R7 irq one cycle later", h_irq, 1);
        local_acc(1, 1, 32'h0000_0001, s);
        idle(3);
        peek(1, v); chk("R3 set keeps others", v, 32'h0000_3C01);
        host_acc(1, 1, 32'h0000_0C00, d, r, y);
        idle(3);
        peek(1, v); chk("R4 host clears ones", v, 32'h0000_3001);
        host_acc(1, 1, 32'h0, d, r, y);
        idle(3);
        peek(1, v); chk("R4 zeros no effect", v, 32'h0000_3001);
        host_acc(1, 1, 32'hFFFF_FFFF, d, r, y);
        idle(3);
        peek(1, v); chk("R4 host never sets", v, 32'h0);
        chk("R7 irq cleared", h_irq, 0);
        h_irq_en = 0;
        local_acc(1, 1, 32'h0000_0040, s);
        idle(3); chk("R7 enable gates irq", h_irq, 0);
        h_irq_en = 1;
        idle(2); chk("R7 irq after enable", h_irq, 1);
        h_irq_en = 0;
    endtask

    task automatic t_read;
        logic d, r, y; logic [31:0] v;
        host_acc(0, 1, 32'hFFFF_FFFF, d, r, y);
        chk("R5 host read data", h_rdata, 32'h0000_0040);
        host_acc(0, 0, 32'hFFFF_FFFF, d, r, y);
        idle(3);
        peek(1, v); chk("R5 read no change l2h", v, 32'h0000_0040);
        peek(0, v); chk("R5 read no change h2l", v, 32'h0);
    endtask

    task automatic t_host_guard;
        logic d, r, y;
        host_acc(0, 0, 32'h0, d, r, y);
        chk("R8 ready low in access", y, 0);
        chk("R8 ready low guard 1", l_ready, 0);
        @(negedge clk); #1 chk("R8 ready low guard 2", l_ready, 0);
        @(negedge clk); #1 chk("R8 ready back", l_ready, 1);
    endtask

    task automatic t_local_guard;
        logic [31:0] v;
        @(negedge clk);
        l_req = 1; l_we = 1; l_sel = 1; l_wdata = 32'h0000_0001;
        #1 chk("R9 local served", l_ready, 1);
        @(negedge clk);
        l_req = 0; l_we = 0;
        h_req = 1; h_we = 1; h_sel = 1; h_wdata = 32'hFFFF_FFFF;
        #1 chk("R9 retry", {h_retry, h_done}, 2'b10);
        @(negedge clk);
        #1 chk("R9 retry guard 2", {h_retry, h_done}, 2'b10);
        @(negedge clk);
        h_req = 0; h_we = 0;
        idle(3);
        peek(1, v); chk("R9 refused write no effect", v, 32'h0000_0041);
    endtask

    task automatic t_tie;
        int s; logic [31:0] v;
        @(negedge clk);
        h_req = 1; h_we = 1; h_sel = 0; h_wdata = 32'h0000_0010;
        l_req = 1; l_we = 1; l_sel = 1; l_wdata = 32'h0000_0020;
        #1 chk("R10 host first", {h_done, l_ready}, 2'b10);
        @(negedge clk);
        h_req = 0; h_we = 0;
        s = 0;
        #1;
        while (!l_ready && s < 50) begin
            s++;
            @(negedge clk); #1;
        end
        chk("R10 stall cycles", s, 2);
        @(negedge clk);
        l_req = 0; l_we = 0;
        idle(3);
        peek(0, v); chk("R10 host write landed", v, 32'h0000_0010);
        peek(1, v); chk("R10 local write landed", v, 32'h0000_0061);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_h2l();
        t_l2h();
        t_read();
        t_host_guard();
        idle(3);
        t_local_guard();
        idle(3);
        t_tie();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule